// File: doc/BRIEF.md
# Sampling Status Register with Clear

This block holds the sticky status flags of a sampled-data acquisition controller. The sampling engine reports single-cycle event pulses: a data word ready to read, a data overwrite, an accepted external sampling clock, a sampling clock that came too early, and a FIFO memory condition. Each pulse latches a flag. The flags stay set until software clears them or a controller command wipes them. Software sees the flags through two byte-wide status locations on a simple register bus. A write to the same two locations acts as a clear mask, with one bit for each flag.

In external clock mode the block also screens incoming sampling clocks. A clock that arrives while the engine is idle goes out as a conversion start and marks the clock-input flag. A clock that arrives while a sampling operation is busy is dropped and raises the clock-error flag. The initialise and set-conditions commands always clear every flag. The start command clears them only while sampling is not busy.

Top module: `samp_status_reg`

## Requirements
- R1: Status byte 0 (address STAT0_ADDR) shows the data-read flag at bit 0, the overwrite error at bit 2, the clock-input flag at bit 4 and the clock-error flag at bit 5. Bits 1, 3, 6 and 7 read 0.
- R2: Status byte 1 (address STAT1_ADDR) shows the FIFO memory flag at bit 4 with every other bit 0. Any other address reads 0x00.
- R3: A pulse on ev_data, ev_ovw or ev_fifo sets its flag on the next clock edge. The flag then holds with no further event until a clear reaches it.
- R4: In clock mode, a sampling clock while not busy drives conv_start high in the same cycle and sets the clock-input flag on the next edge.
- R5: In clock mode, a sampling clock while busy leaves conv_start low and sets the clock-error flag on the next edge.
- R6: A write to STAT0_ADDR clears the flags whose clear bits are 1: bit 0 the data-read flag, bit 2 the overwrite error, bit 4 the clock-input flag, bit 5 the clock error. Zero bits and bits 1, 3, 6 and 7 change nothing.
- R7: A write to STAT1_ADDR with bit 4 set clears the FIFO memory flag. Its other bits change nothing.
- R8: cmd_init or cmd_cond clears all flags on the next edge.
- R9: cmd_start clears all flags when samp_busy is low and changes nothing when samp_busy is high.
- R10: When a set event and a clear reach the same flag in the same cycle, the flag ends up set.
- R11: Synchronous reset clears every flag. Bus writes never set a flag.
- R12: Outside clock mode a sampling clock produces no conv_start and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_mode | input | 1 | External sampling clock mode selected |
| samp_busy | input | 1 | Sampling operation in progress |
| samp_clk_in | input | 1 | External sampling clock pulse |
| ev_data | input | 1 | Data-ready event pulse |
| ev_ovw | input | 1 | Data overwrite event pulse |
| ev_fifo | input | 1 | FIFO memory event pulse |
| cmd_init | input | 1 | Initialise command pulse |
| cmd_cond | input | 1 | Set-sampling-conditions command pulse |
| cmd_start | input | 1 | Start-sampling command pulse |
| bus_wr | input | 1 | Bus write strobe (clear mask) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Clear mask |
| bus_rdata | output | 8 | Status byte for bus_addr |
| conv_start | output | 1 | Accepted sampling clock, starts a conversion |

## Verification
Each flag is set alone and then in combination, so the tests catch a bit at the wrong position and two flags wired together. Sampling clocks are applied idle, busy and outside clock mode, which separates an accepted clock, a discarded clock and an ignored clock. Clear masks go in empty, partial, unused-bit-only and complete, and collide with set events in the same cycle. The start command is issued both busy and idle, which exposes a start command that ignores the busy guard.

// File: rtl/samp_status_reg.sv
module samp_status_reg #(
  parameter int ADDR_W     = 4,
  parameter int STAT0_ADDR = 6,
  parameter int STAT1_ADDR = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_mode,
  input  logic              samp_busy,
  input  logic              samp_clk_in,
  input  logic              ev_data,
  input  logic              ev_ovw,
  input  logic              ev_fifo,
  input  logic              cmd_init,
  input  logic              cmd_cond,
  input  logic              cmd_start,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              conv_start
);
  localparam logic [ADDR_W-1:0] A0 = ADDR_W'(STAT0_ADDR);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(STAT1_ADDR);

  // flg: 0 data-read, 1 overwrite, 2 clock-input, 3 clock-error, 4 fifo
  logic [4:0] flg;
  logic [4:0] set_v, clr_v;
  logic       wr0, wr1, clk_ok, clk_err, cmd_clr;
  logic [7:0] stat0, stat1;

  assign wr0     = bus_wr && (bus_addr == A0);
  assign wr1     = bus_wr && (bus_addr == A1);
  assign clk_ok  = clk_mode && samp_clk_in && !samp_busy;
  assign clk_err = clk_mode && samp_clk_in && samp_busy;
  assign cmd_clr = cmd_init || cmd_cond || (cmd_start && !samp_busy);

  assign set_v = {ev_fifo, clk_err, clk_ok, ev_ovw, ev_data};
  assign clr_v = {wr1 && bus_wdata[4], wr0 && bus_wdata[5], wr0 && bus_wdata[4],
                  wr0 && bus_wdata[2], wr0 && bus_wdata[0]} | {5{cmd_clr}};

  always_ff @(posedge clk) begin
    if (rst) flg <= '0;
    else     flg <= set_v | (flg & ~clr_v);
  end

  assign stat0 = {2'b00, flg[3], flg[2], 1'b0, flg[1], 1'b0, flg[0]};
  assign stat1 = {3'b000, flg[4], 4'b0000};

  assign bus_rdata  = (bus_addr == A0) ? stat0 :
                      (bus_addr == A1) ? stat1 : 8'h00;
  assign conv_start = clk_ok;
endmodule

// File: rtl/samp_status_chk.sv
module samp_status_chk #(
  parameter int ADDR_W     = 4,
  parameter int STAT0_ADDR = 6,
  parameter int STAT1_ADDR = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_mode,
  input logic              samp_busy,
  input logic              samp_clk_in,
  input logic              ev_data,
  input logic              ev_ovw,
  input logic              ev_fifo,
  input logic              cmd_init,
  input logic              cmd_cond,
  input logic              cmd_start,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              conv_start,
  input logic [4:0]        flg
);
  localparam logic [ADDR_W-1:0] A0 = ADDR_W'(STAT0_ADDR);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(STAT1_ADDR);

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A0) |-> ((bus_rdata & 8'hCA) == 8'h00)); // R1
  AST_FIFO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flg[4] && !(bus_wr && bus_addr == A1 && bus_wdata[4]) && !cmd_init && !cmd_cond
     && !(cmd_start && !samp_busy)) |=> flg[4]); // R3
  AST_BUSY_NO_CONV: assert property (@(posedge clk) disable iff (rst)
    samp_busy |-> !conv_start); // R5
  AST_CLK_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    (clk_mode && samp_clk_in && samp_busy) |=> flg[3]); // R5
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cmd_init && !ev_data && !ev_ovw && !ev_fifo && !samp_clk_in) |=> (flg == 5'b0)); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ev_ovw |=> flg[1]); // R10
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (flg == 5'b0)); // R11
  AST_NO_MODE_NO_CONV: assert property (@(posedge clk) disable iff (rst)
    !clk_mode |-> !conv_start); // R12
endmodule

bind samp_status_reg samp_status_chk #(
  .ADDR_W(ADDR_W), .STAT0_ADDR(STAT0_ADDR), .STAT1_ADDR(STAT1_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .clk_mode(clk_mode), .samp_busy(samp_busy),
  .samp_clk_in(samp_clk_in), .ev_data(ev_data), .ev_ovw(ev_ovw), .ev_fifo(ev_fifo),
  .cmd_init(cmd_init), .cmd_cond(cmd_cond), .cmd_start(cmd_start), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .conv_start(conv_start), .flg(flg)
);

// File: tb/sim_samp_status_reg.sv
module sim_samp_status_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_mode = 0, samp_busy = 0, samp_clk_in = 0;
  logic ev_data = 0, ev_ovw = 0, ev_fifo = 0;
  logic cmd_init = 0, cmd_cond = 0, cmd_start = 0;
  logic bus_wr = 0;
  logic [3:0] bus_addr = 4'd6;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic conv_start;
  int checks = 0, errors = 0;
  bit done = 0;

  samp_status_reg u0 (
    .clk(clk), .rst(rst), .clk_mode(clk_mode), .samp_busy(samp_busy),
    .samp_clk_in(samp_clk_in), .ev_data(ev_data), .ev_ovw(ev_ovw), .ev_fifo(ev_fifo),
    .cmd_init(cmd_init), .cmd_cond(cmd_cond), .cmd_start(cmd_start), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_start(conv_start)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic chk_stat(input string req, input logic [7:0] e0, input logic [7:0] e1);
    logic [7:0] v;
    rd(4'd6, v); chk({req, " byte0"}, v, e0);
    rd(4'd7, v); chk({req, " byte1"}, v, e1);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick(); bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic wipe();
    samp_busy = 0; cmd_init = 1; tick(); cmd_init = 0;
  endtask

  task automatic set_all();
    clk_mode = 1; samp_busy = 0; samp_clk_in = 1; ev_data = 1; ev_ovw = 1; ev_fifo = 1;
    tick();
    ev_data = 0; ev_ovw = 0; ev_fifo = 0; samp_busy = 1;
    tick();
    samp_clk_in = 0; samp_busy = 0; clk_mode = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk_stat("R11 reset", 8'h00, 8'h00);
    rd(4'd3, v); chk("R2 other address", v, 8'h00);
  endtask

  task automatic t_events();
    ev_data = 1; tick(); ev_data = 0;
    chk_stat("R3 data event", 8'h01, 8'h00);
    ev_ovw = 1; tick(); ev_ovw = 0;
    chk_stat("R1 overwrite bit2", 8'h05, 8'h00);
    ev_fifo = 1; tick(); ev_fifo = 0;
    repeat (3) tick();
    chk_stat("R3 sticky hold / R2 fifo bit4", 8'h05, 8'h10);
    wipe();
  endtask

  task automatic t_clkmode();
    clk_mode = 1; samp_busy = 0; samp_clk_in = 1; #1;
    chk("R4 conv_start idle", {7'b0, conv_start}, 8'h01);
    tick(); samp_clk_in = 0;
    chk_stat("R4 clock-input flag", 8'h10, 8'h00);
    samp_busy = 1; samp_clk_in = 1; #1;
    chk("R5 conv_start busy", {7'b0, conv_start}, 8'h00);
    tick(); samp_clk_in = 0; samp_busy = 0; clk_mode = 0;
    chk_stat("R5 clock-error flag", 8'h30, 8'h00);
  endtask

  task automatic t_clear0();
    ev_data = 1; ev_ovw = 1; tick(); ev_data = 0; ev_ovw = 0;
    chk_stat("R1 all byte0 flags", 8'h35, 8'h00);
    wr(4'd6, 8'h00);
    chk_stat("R6 zero mask", 8'h35, 8'h00);
    wr(4'd6, 8'hCA);
    chk_stat("R6 unused bits", 8'h35, 8'h00);
    wr(4'd6, 8'h04);
    chk_stat("R6 clear overwrite", 8'h31, 8'h00);
    wr(4'd6, 8'h21);
    chk_stat("R6 clear data+clkerr", 8'h10, 8'h00);
    wr(4'd6, 8'h10);
    chk_stat("R6 clear clock-input", 8'h00, 8'h00);
  endtask

  task automatic t_clear1();
    ev_fifo = 1; ev_data = 1; tick(); ev_fifo = 0; ev_data = 0;
    wr(4'd7, 8'hEF);
    chk_stat("R7 other bits", 8'h01, 8'h10);
    wr(4'd7, 8'h10);
    chk_stat("R7 clear fifo", 8'h01, 8'h00);
    wipe();
  endtask

  task automatic t_cmds();
    set_all();
    chk_stat("R8 preset", 8'h35, 8'h10);
    cmd_init = 1; tick(); cmd_init = 0;
    chk_stat("R8 init", 8'h00, 8'h00);
    set_all();
    cmd_cond = 1; tick(); cmd_cond = 0;
    chk_stat("R8 conditions", 8'h00, 8'h00);
  endtask

  task automatic t_start();
    ev_ovw = 1; ev_fifo = 1; tick(); ev_ovw = 0; ev_fifo = 0;
    samp_busy = 1; cmd_start = 1; tick(); cmd_start = 0;
    chk_stat("R9 start while busy", 8'h04, 8'h10);
    samp_busy = 0; cmd_start = 1; tick(); cmd_start = 0;
    chk_stat("R9 start idle", 8'h00, 8'h00);
  endtask

  task automatic t_setwins();
    ev_ovw = 1; bus_wr = 1; bus_addr = 4'd6; bus_wdata = 8'h04; tick();
    ev_ovw = 0; bus_wr = 0; bus_wdata = 0;
    chk_stat("R10 set vs write clear", 8'h04, 8'h00);
    ev_fifo = 1; cmd_init = 1; tick(); ev_fifo = 0; cmd_init = 0;
    chk_stat("R10 set vs init", 8'h00, 8'h10);
    wipe();
  endtask

  task automatic t_readonly();
    wr(4'd6, 8'hFF);
    wr(4'd7, 8'hFF);
    chk_stat("R11 writes never set", 8'h00, 8'h00);
    set_all();
    rst = 1; tick(); rst = 0;
    chk_stat("R11 reset after flags", 8'h00, 8'h00);
  endtask

  task automatic t_nomode();
    clk_mode = 0; samp_busy = 0; samp_clk_in = 1; #1;
    chk("R12 no conv idle", {7'b0, conv_start}, 8'h00);
    tick(); samp_busy = 1; #1;
    chk("R12 no conv busy", {7'b0, conv_start}, 8'h00);
    tick(); samp_clk_in = 0; samp_busy = 0;
    chk_stat("R12 flags unchanged", 8'h00, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_events();
    t_clkmode();
    t_clear0();
    t_clear1();
    t_cmds();
    t_start();
    t_setwins();
    t_readonly();
    t_nomode();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule